// File: doc/BRIEF.md
# Dual Timer Interrupt Aggregator

This block holds two free-running, auto-reloading timers and merges their expiry events into a two-bit flag register. The register sits on a simple 16-bit register bus. A single timer interrupt request line goes from the flags to a CPU. Each timer divides the clock by its own prescale value, then counts its own reload period in prescaled ticks. When a timer expires, it sets its flag and starts the next period by itself.

Software clears flags by writing ones. A bit written as zero is never touched, so an interrupt routine can clear exactly the source it handled without a read-modify-write. A hardware set that lands in the same cycle as a clear of that same bit wins. A set of the other bit is never disturbed. The CPU-side pending bit clears when the CPU acknowledges entry into the routine. An in-service state then holds the request low until the return-from-interrupt. If any flag is still set at that point, the request rises again, so a source that was left unserviced, or that arrived during service, is taken on the next entry.

Top module: `tmr_irq_agg`

## Requirements
- R1: A read returns the timer 0 flag in bit 0 and the timer 1 flag in bit 1. Bits 15:2 always read as zero.
- R2: A bus write with a 1 in bit 0 or bit 1 clears that flag at the next clock edge. A 0 in a bit leaves that flag unchanged, and data bits 15:2 have no effect.
- R3: When a timer expiry and a bus clear hit the same flag in the same cycle, the flag stays 1.
- R4: An enabled timer with prescale D and period P sets its flag every max(D,1)*max(P,1) clock cycles, so a value of zero acts as one.
- R5: Expiry reloads the timer with no bus access, so the flag sets again one full period later.
- R6: While not in service, the pending output `irq_pend` goes high one cycle after any flag reads as set.
- R7: `cpu_ack` clears `irq_pend` at the next edge and enters service. While in service, `irq_pend` stays low whatever the flags do.
- R8: After `cpu_reti`, `irq_pend` rises one cycle after service ends if any flag is still set. It stays low if both flags are clear.
- R9: A clear of one flag never removes the other flag, even when the other flag is set by hardware during service. That other flag then triggers the interrupt again after return.
- R10: Synchronous active-low reset clears both flags, both timer counts, the in-service state and `irq_pend`. After release, an enabled timer first expires exactly max(D,1)*max(P,1) cycles later.
- R11: A flag that expires again while already set stays set, and no count is kept: one clear leaves it at 0.
- R12: A timer whose enable is low holds its count at zero and never sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| t0_en | input | 1 | Timer 0 run enable |
| t0_div | input | 8 | Timer 0 prescale divisor (0 acts as 1) |
| t0_period | input | 16 | Timer 0 reload period in ticks (0 acts as 1) |
| t1_en | input | 1 | Timer 1 run enable |
| t1_div | input | 8 | Timer 1 prescale divisor (0 acts as 1) |
| t1_period | input | 16 | Timer 1 reload period in ticks (0 acts as 1) |
| bus_wr | input | 1 | Write strobe for the flag register |
| bus_wdata | input | 16 | Write data; ones clear flags |
| bus_rdata | output | 16 | Flag register read value |
| cpu_ack | input | 1 | CPU acknowledges interrupt entry |
| cpu_reti | input | 1 | CPU returns from the interrupt routine |
| irq_pend | output | 1 | Timer interrupt pending toward the CPU |

## Verification
A wrong flag state shows up on `bus_rdata` one edge after the expiry or write that caused it. A lost or stale flag then appears on `irq_pend` no later than one cycle after service ends. A miscounting prescaler or period counter is exposed by measuring the cycles between two successive flag sets for several divisor and period pairs, including the zero values. The race cases are driven on exact cycles: a clear colliding with an expiry of the same bit, and a two-bit clear while the other timer fires every cycle. The bench then checks that the re-trigger after return comes exactly two edges after `cpu_reti`.

// File: rtl/tmr_irq_pkg.sv
// Shared constants and types for the timer interrupt aggregator.
package tmr_irq_pkg;
    localparam int NUM_TMR = 2;        // number of timers / flag bits
    localparam int BUS_W   = 16;       // register bus data width
    localparam int PRE_W   = 8;        // prescale divisor width
    localparam int PER_W   = 16;       // reload period width
    typedef logic [NUM_TMR-1:0] tmr_vec_t;
endpackage

// File: rtl/tmr_ch.sv
// One auto-reload timer channel.
// A prescaler divides the clock by max(div,1) and produces ticks. A period
// counter counts max(period,1) ticks and pulses 'expire' for one cycle on the
// last tick, then restarts from zero. Assumes div/period are quasi-static;
// a change mid-period takes effect on the next comparison.
// While 'en' is low both counts are held at zero.
module tmr_ch #(
    parameter int PRE_W = 8,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] div,
    input  logic [PER_W-1:0] period,
    output logic             expire
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PER_W-1:0] per_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic [PER_W-1:0] per_lim;
    logic             tick;

    // Terminal values; zero programs behave as one.
    always_comb begin
        pre_lim = (div == '0)    ? '0 : div - 1'b1;
        per_lim = (period == '0) ? '0 : period - 1'b1;
    end

    assign tick   = en && (pre_cnt >= pre_lim);
    assign expire = tick && (per_cnt >= per_lim);

    // Prescaler: counts clock cycles up to the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // Period counter: counts ticks and reloads itself on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            per_cnt <= '0;
        end else if (expire) begin
            per_cnt <= '0;
        end else if (tick) begin
            per_cnt <= per_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_flag_reg.sv
// Aggregated flag register.
// Each bit is set by a one-cycle expiry pulse and cleared by a one in the
// clear mask. When set and clear meet on the same bit the set wins. Bits are
// independent, so a clear of one never touches another.
module tmr_flag_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pulse,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit storage: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else if (set_pulse[i]) begin
                flags_q[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/tmr_irq_pend.sv
// CPU-side pending bit and in-service tracking.
// Pending is set when any flag is set and the CPU is not in service. It is
// cleared by acknowledge. Acknowledge enters service; return leaves it, after
// which pending re-arms from whatever flags remain. Assumes ack and reti
// are single-cycle pulses.
module tmr_irq_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic any_flag,
    input  logic cpu_ack,
    input  logic cpu_reti,
    output logic irq_pend,
    output logic in_svc
);
    logic pend_q;
    logic svc_q;

    // In-service state: entered on acknowledge, left on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= 1'b0;
        end else if (cpu_ack) begin
            svc_q <= 1'b1;
        end else if (cpu_reti) begin
            svc_q <= 1'b0;
        end
    end

    // Pending bit: self-clears on acknowledge, re-arms outside service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (cpu_ack) begin
            pend_q <= 1'b0;
        end else if (any_flag && !svc_q) begin
            pend_q <= 1'b1;
        end
    end

    assign irq_pend = pend_q;
    assign in_svc   = svc_q;
endmodule

// File: rtl/tmr_irq_agg.sv
// Dual timer interrupt aggregator (top).
// Two timer channels feed a write-one-to-clear flag register on a 16-bit
// bus. The OR of the flags drives one interrupt pending bit that is gated by
// the CPU's in-service state. Reads are combinational from the flags.
module tmr_irq_agg
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             t0_en,
    input  logic [PRE_W-1:0] t0_div,
    input  logic [PER_W-1:0] t0_period,
    input  logic             t1_en,
    input  logic [PRE_W-1:0] t1_div,
    input  logic [PER_W-1:0] t1_period,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             cpu_ack,
    input  logic             cpu_reti,
    output logic             irq_pend
);
    localparam int PAD_W = BUS_W - NUM_TMR;

    logic [NUM_TMR-1:0]            t_en;
    logic [NUM_TMR-1:0][PRE_W-1:0] t_div;
    logic [NUM_TMR-1:0][PER_W-1:0] t_per;
    tmr_vec_t                      t_exp;
    tmr_vec_t                      clr_mask;
    tmr_vec_t                      flags_q;
    logic                          in_svc;
    logic                          unused_wdata_hi;

    // Gather per-timer controls into arrays for the generate loop.
    always_comb begin
        t_en  = {t1_en, t0_en};
        t_div = {t1_div, t0_div};
        t_per = {t1_period, t0_period};
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        tmr_ch #(
            .PRE_W (PRE_W),
            .PER_W (PER_W)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (t_en[i]),
            .div    (t_div[i]),
            .period (t_per[i]),
            .expire (t_exp[i])
        );
    end

    // Write-one-to-clear mask from the bus; upper data bits are ignored.
    assign clr_mask        = bus_wr ? bus_wdata[NUM_TMR-1:0] : '0;
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:NUM_TMR];

    tmr_flag_reg #(
        .N (NUM_TMR)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (t_exp),
        .clr_mask  (clr_mask),
        .flags     (flags_q)
    );

    tmr_irq_pend u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_flag (|flags_q),
        .cpu_ack  (cpu_ack),
        .cpu_reti (cpu_reti),
        .irq_pend (irq_pend),
        .in_svc   (in_svc)
    );

    assign bus_rdata = {{PAD_W{1'b0}}, flags_q};
endmodule

// File: rtl/tmr_irq_agg_chk.sv
// Assertion checker for tmr_irq_agg, attached by bind below.
module tmr_irq_agg_chk
    import tmr_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input tmr_vec_t         flags,
    input tmr_vec_t         set_pulse,
    input logic             bus_wr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             cpu_ack,
    input logic             in_svc,
    input logic             irq_pend
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_bitchk
        // R3: an expiry always leaves its flag set, even against a clear.
        assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_pulse[i] |=> flags[i]);
        // R2: a one written without a colliding expiry clears the flag.
        assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_wdata[i] && !set_pulse[i]) |=> !flags[i]);
        // R11 / R9: a set flag only drops through its own clear bit.
        assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(bus_wr && bus_wdata[i])) |=> flags[i]);
    end

    // R1: upper read bits are zero and lower bits mirror the flags.
    assert_readmap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[BUS_W-1:NUM_TMR] == '0) && (bus_rdata[NUM_TMR-1:0] == flags));
    // R6: any flag outside service raises the pending bit next cycle.
    assert_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flags) && !in_svc && !cpu_ack) |=> irq_pend);
    // R7: acknowledge clears the pending bit.
    assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !irq_pend);
    // R7: no new request rises while in service.
    assert_svc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc |=> !$rose(irq_pend));
    // R8: leaving service with a flag still set re-raises the request.
    assert_retrigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_svc) && (|flags) && !cpu_ack) |=> irq_pend);
    // R10: reset empties flags, service state and pending bit.
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && !irq_pend && !in_svc));
endmodule

bind tmr_irq_agg tmr_irq_agg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags_q),
    .set_pulse (t_exp),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_ack   (cpu_ack),
    .in_svc    (in_svc),
    .irq_pend  (irq_pend)
);

// File: tb/sim_tmr_irq_agg.sv
module sim_tmr_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        t0_en, t1_en;
    logic [7:0]  t0_div, t1_div;
    logic [15:0] t0_period, t1_period;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        cpu_ack, cpu_reti;
    logic        irq_pend;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tmr_irq_agg u0 (
        .clk(clk), .rst_n(rst_n),
        .t0_en(t0_en), .t0_div(t0_div), .t0_period(t0_period),
        .t1_en(t1_en), .t1_div(t1_div), .t1_period(t1_period),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .irq_pend(irq_pend)
    );

    // Prescale, period, expected cycles between timer 0 flag sets (R4, R5).
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{4, 3, 12}, '{1, 5, 5}, '{0, 4, 4},
        '{3, 0, 3},  '{2, 7, 14}, '{1, 1, 1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; t0_en = 1'b0; t1_en = 1'b0;
        t0_div = 8'd1; t1_div = 8'd1; t0_period = 16'd1; t1_period = 16'd1;
        bus_wr = 1'b0; bus_wdata = '0; cpu_ack = 1'b0; cpu_reti = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] d);
        bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic ack();
        cpu_ack = 1'b1; @(negedge clk); cpu_ack = 1'b0;
    endtask

    task automatic reti();
        cpu_reti = 1'b1; @(negedge clk); cpu_reti = 1'b0;
    endtask

    task automatic wait_flag(input int b, output int n);
        n = 0;
        while (!bus_rdata[b] && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        do_reset();
        @(negedge clk);
        // R10: reset state
        chk("R10 reset rdata", int'(bus_rdata), 0);
        chk("R10 reset irq", int'(irq_pend), 0);

        // R4 / R5: period table
        for (int v = 0; v < NVEC; v++) begin
            int c;
            t0_en = 1'b0; @(negedge clk);
            t0_div = 8'(VEC[v][0]); t0_period = 16'(VEC[v][1]); t0_en = 1'b1;
            wait_flag(0, n);
            wr(16'h0001);
            c = 1;
            while (!bus_rdata[0] && c < 5000) begin
                @(negedge clk);
                c++;
            end
            chk($sformatf("R4 R5 period vec%0d", v), c, VEC[v][2]);
        end

        // R12: disabled timers never set flags
        do_reset();
        cyc(30);
        chk("R12 disabled rdata", int'(bus_rdata), 0);
        chk("R12 disabled irq", int'(irq_pend), 0);

        // R1: timer 1 alone sets bit 1 only
        t1_div = 8'd2; t1_period = 16'd3; t1_en = 1'b1;
        wait_flag(1, n);
        t1_en = 1'b0;
        chk("R1 bit map t1", int'(bus_rdata), 2);

        // R6 R7 R2 R8: both fire together, serviced one at a time
        do_reset();
        t0_period = 16'd10; t1_period = 16'd10;
        t0_en = 1'b1; t1_en = 1'b1;
        wait_flag(0, n);
        chk("R1 both set", int'(bus_rdata), 3);
        chk("R6 irq not yet", int'(irq_pend), 0);
        t0_en = 1'b0; t1_en = 1'b0;
        @(negedge clk);
        chk("R6 irq raised", int'(irq_pend), 1);
        ack();
        chk("R7 ack clears", int'(irq_pend), 0);
        cyc(3);
        chk("R7 held in service", int'(irq_pend), 0);
        wr(16'h0001);
        chk("R2 clear bit0 only", int'(bus_rdata), 2);
        wr(16'h0000);
        chk("R2 zero write", int'(bus_rdata), 2);
        wr(16'hFFFC);
        chk("R2 upper bits ignored", int'(bus_rdata), 2);
        reti();
        chk("R8 one cycle after reti", int'(irq_pend), 0);
        @(negedge clk);
        chk("R8 retrigger", int'(irq_pend), 1);
        ack();
        wr(16'h0002);
        reti();
        cyc(3);
        chk("R8 no retrigger when clear", int'(irq_pend), 0);
        chk("R8 flags empty", int'(bus_rdata), 0);

        // R3: clear collides with expiry every cycle on bit 0
        do_reset();
        t0_en = 1'b1;
        cyc(3);
        wr(16'h0001);
        chk("R3 set wins", int'(bus_rdata[0]), 1);

        // R9: in service, clear both while timer 1 fires every cycle
        ack();
        t0_en = 1'b0; t1_en = 1'b1;
        cyc(2);
        chk("R9 both set", int'(bus_rdata), 3);
        wr(16'h0003);
        chk("R9 bit1 kept bit0 cleared", int'(bus_rdata), 2);
        t1_en = 1'b0;
        reti();
        @(negedge clk);
        chk("R9 retrigger from kept flag", int'(irq_pend), 1);

        // R11: repeated expiry does not accumulate
        do_reset();
        t0_period = 16'd2; t0_en = 1'b1;
        cyc(11);
        t0_en = 1'b0;
        @(negedge clk);
        chk("R11 still set", int'(bus_rdata), 1);
        wr(16'h0001);
        cyc(3);
        chk("R11 single clear", int'(bus_rdata), 0);

        // R10: mid-run reset, then exact first expiry after release
        t0_en = 1'b1; t0_period = 16'd1;
        cyc(3);
        rst_n = 1'b0; t0_div = 8'd2; t0_period = 16'd3;
        @(negedge clk);
        chk("R10 midrun flags", int'(bus_rdata), 0);
        chk("R10 midrun irq", int'(irq_pend), 0);
        rst_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bus_rdata[0] && n < 5000);
        chk("R10 first expiry after release", n, 6);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule